// File: doc/BRIEF.md
# Post-Modify Load/Store Microinstruction Unit

This unit carries out the memory-access microinstructions of a small 16-bit microengine. It accepts one 16-bit microinstruction on a start strobe and reads its operands from an external 16-entry register file. It makes a single byte or halfword access on a simple request/ready memory port and writes the results back through one register-file write port. It then signals completion with a one-cycle done pulse.

There are two kinds of access. Register-indirect byte and halfword loads and stores use the register named by the second register field as the address. After the transfer, that register is stepped by an amount chosen by a 4-bit modifier. Direct halfword loads and stores take an 8-bit halfword index straight from the microinstruction. A sequencer upstream issues a microinstruction, waits for done, and then issues the next.

Top module: `pm_lsu`

## Requirements
- R1: After reset, and while no microinstruction is in progress, `mem_req_o`, `rf_wr_en_o` and `done_o` are low.
- R2: The fields of a microinstruction are: opcode in bits [15:12], data register X in [11:8], address register Y in [7:4], modifier in [3:0], and the direct halfword index in [7:0]. A start is accepted only while idle and only for opcodes 2, 3, 5, 6, 7 and D (hex). Any other opcode causes no memory request, no register write and no done pulse.
- R3: Opcode 6 reads a byte (`mem_half_o`=0) at the address held in Y. It writes `mem_rdata_i[7:0]` into the low byte of X and keeps the high byte of X.
- R4: Opcode D reads a halfword (`mem_half_o`=1) at the address held in Y and writes all 16 bits of it into X.
- R5: Opcode 7 writes a byte (`mem_we_o`=1, `mem_half_o`=0) to the address held in Y. The write data is `{8'h00, X[7:0]}`.
- R6: Opcode 5 writes the full halfword of X to the address held in Y (`mem_we_o`=1, `mem_half_o`=1).
- R7: After an indirect operation, Y is rewritten according to the modifier. Modifier values 0 to 3 add 1 to 4. Values 4 to 7 subtract 1 to 4. The arithmetic wraps modulo 2^16. A modifier of 8 or more makes no write to Y.
- R8: The memory address of an indirect access is Y's value from before the update.
- R9: Opcode 2 loads a halfword into X, and opcode 3 stores X as a halfword. Both use the byte address `{7'b0, index, 1'b0}`.
- R10: If X and Y name the same register on an indirect load, the register ends up holding the updated address.
- R11: The sequence of an operation is fixed:
  - the request is held with stable address, size, write enable and data until `mem_rdy_i`;
  - then one cycle for the load data write (loads only);
  - then one cycle for the Y write (when the modifier applies);
  - then a one-cycle `done_o`.
  A start during an operation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uinstr_i | input | 16 | Microinstruction |
| ustart_i | input | 1 | Start strobe for `uinstr_i` |
| done_o | output | 1 | One-cycle completion pulse |
| rf_rd_x_addr_o | output | 4 | Register file read address, data register |
| rf_rd_x_data_i | input | 16 | Register file read data, data register |
| rf_rd_y_addr_o | output | 4 | Register file read address, address register |
| rf_rd_y_data_i | input | 16 | Register file read data, address register |
| rf_wr_en_o | output | 1 | Register file write enable |
| rf_wr_addr_o | output | 4 | Register file write address |
| rf_wr_data_o | output | 16 | Register file write data |
| mem_req_o | output | 1 | Memory request |
| mem_addr_o | output | 16 | Memory byte address |
| mem_half_o | output | 1 | 1 = halfword access, 0 = byte |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, byte reads in [7:0] |
| mem_rdy_i | input | 1 | Memory completes the request this cycle |

## Verification
A wrong internal state in this unit appears at the ports within one clock. A bad captured operand or a bad decode shows up in the first request cycle, as a wrong address, size, direction or write data. A bad modifier sum or merge shows up in the register write cycle, as a wrong write address or data. A stuck or skipped sequencer state shows up as a missing, doubled or misplaced request, write or done cycle. The bench therefore predicts the exact port pattern of every cycle and compares it on every clock. Register contents are compared again once the run has finished.

// File: rtl/pm_lsu_pkg.sv
package pm_lsu_pkg;

  localparam int unsigned INSTR_W = 16;
  localparam int unsigned OPC_W   = 4;
  localparam int unsigned REG_AW  = 4;
  localparam int unsigned MOD_W   = 4;
  localparam int unsigned DIR_W   = 8;

  localparam logic [OPC_W-1:0] OPC_LDH_DIR = 4'h2;
  localparam logic [OPC_W-1:0] OPC_STH_DIR = 4'h3;
  localparam logic [OPC_W-1:0] OPC_STH_IND = 4'h5;
  localparam logic [OPC_W-1:0] OPC_LDB_IND = 4'h6;
  localparam logic [OPC_W-1:0] OPC_STB_IND = 4'h7;
  localparam logic [OPC_W-1:0] OPC_LDH_IND = 4'hD;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_WDATA,
    ST_WADDR,
    ST_DONE
  } lsu_state_e;

  typedef struct packed {
    logic              valid;
    logic              is_load;
    logic              is_half;
    logic              indirect;
    logic              upd_en;
    logic [REG_AW-1:0] rx;
    logic [REG_AW-1:0] ry;
    logic [MOD_W-1:0]  mod;
    logic [DIR_W-1:0]  dir;
  } lsu_uop_t;

endpackage

// File: rtl/pm_lsu_rst_sync.sv
module pm_lsu_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/pm_lsu_decode.sv
module pm_lsu_decode
  import pm_lsu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output lsu_uop_t           uop_o
);

  localparam int unsigned OPC_LSB = INSTR_W - OPC_W;
  localparam int unsigned RX_LSB  = OPC_LSB - REG_AW;
  localparam int unsigned RY_LSB  = RX_LSB - REG_AW;

  logic [OPC_W-1:0] opc;

  assign opc = instr_i[OPC_LSB +: OPC_W];

  always_comb begin
    uop_o          = '0;
    uop_o.rx       = instr_i[RX_LSB +: REG_AW];
    uop_o.ry       = instr_i[RY_LSB +: REG_AW];
    uop_o.mod      = instr_i[0 +: MOD_W];
    uop_o.dir      = instr_i[0 +: DIR_W];
    unique case (opc)
      OPC_LDB_IND: begin
        uop_o.valid    = 1'b1;
        uop_o.is_load  = 1'b1;
        uop_o.indirect = 1'b1;
      end
      OPC_LDH_IND: begin
        uop_o.valid    = 1'b1;
        uop_o.is_load  = 1'b1;
        uop_o.is_half  = 1'b1;
        uop_o.indirect = 1'b1;
      end
      OPC_STB_IND: begin
        uop_o.valid    = 1'b1;
        uop_o.indirect = 1'b1;
      end
      OPC_STH_IND: begin
        uop_o.valid    = 1'b1;
        uop_o.is_half  = 1'b1;
        uop_o.indirect = 1'b1;
      end
      OPC_LDH_DIR: begin
        uop_o.valid    = 1'b1;
        uop_o.is_load  = 1'b1;
        uop_o.is_half  = 1'b1;
      end
      OPC_STH_DIR: begin
        uop_o.valid    = 1'b1;
        uop_o.is_half  = 1'b1;
      end
      default: uop_o.valid = 1'b0;
    endcase
    // the step applies only to indirect forms whose modifier top bit is clear
    uop_o.upd_en = uop_o.indirect & ~uop_o.mod[MOD_W-1];
  end

endmodule

// File: rtl/pm_lsu_addrmod.sv
module pm_lsu_addrmod #(
  parameter int unsigned AW    = 16,
  parameter int unsigned MOD_W = 4
) (
  input  logic [AW-1:0]    base_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic [AW-1:0]    next_o
);

  localparam int unsigned SEL_W = MOD_W - 1;
  localparam int unsigned N_STP = 1 << SEL_W;
  localparam int unsigned HALF  = N_STP / 2;

  logic [AW-1:0] cand [N_STP];

  for (genvar i = 0; i < N_STP; i++) begin : g_step
    if (i < HALF) begin : g_inc
      assign cand[i] = base_i + AW'(i + 1);
    end else begin : g_dec
      assign cand[i] = base_i - AW'(i - HALF + 1);
    end
  end

  assign next_o = mod_i[MOD_W-1] ? base_i : cand[mod_i[SEL_W-1:0]];

endmodule

// File: rtl/pm_lsu_ctrl.sv
module pm_lsu_ctrl
  import pm_lsu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       dec_valid_i,
  input  logic       is_load_i,
  input  logic       upd_en_i,
  input  logic       mem_rdy_i,
  output lsu_state_e state_o,
  output logic       accept_o,
  output logic       capture_o
);

  lsu_state_e state_q, state_d;

  assign accept_o  = (state_q == ST_IDLE) & start_i & dec_valid_i;
  assign capture_o = (state_q == ST_ACCESS) & mem_rdy_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_o) state_d = ST_ACCESS;
      end
      ST_ACCESS: begin
        if (mem_rdy_i) begin
          if (is_load_i)     state_d = ST_WDATA;
          else if (upd_en_i) state_d = ST_WADDR;
          else               state_d = ST_DONE;
        end
      end
      ST_WDATA: begin
        state_d = upd_en_i ? ST_WADDR : ST_DONE;
      end
      ST_WADDR: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/pm_lsu.sv
module pm_lsu
  import pm_lsu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [INSTR_W-1:0]    uinstr_i,
  input  logic                  ustart_i,
  output logic                  done_o,
  output logic [REG_AW-1:0]     rf_rd_x_addr_o,
  input  logic [DATA_W-1:0]     rf_rd_x_data_i,
  output logic [REG_AW-1:0]     rf_rd_y_addr_o,
  input  logic [DATA_W-1:0]     rf_rd_y_data_i,
  output logic                  rf_wr_en_o,
  output logic [REG_AW-1:0]     rf_wr_addr_o,
  output logic [DATA_W-1:0]     rf_wr_data_o,
  output logic                  mem_req_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic                  mem_half_o,
  output logic                  mem_we_o,
  output logic [DATA_W-1:0]     mem_wdata_o,
  input  logic [DATA_W-1:0]     mem_rdata_i,
  input  logic                  mem_rdy_i
);

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned HI_W    = DATA_W - BYTE_W;
  localparam int unsigned DPAD_W  = ADDR_W - DIR_W - 1;

  logic        rst_n_int;
  lsu_uop_t    dec_uop;
  lsu_uop_t    uop_q;
  lsu_state_e  state;
  logic        accept;
  logic        capture;
  logic [DATA_W-1:0] rx_q;
  logic [ADDR_W-1:0] ry_q;
  logic [DATA_W-1:0] rdata_q;
  logic [ADDR_W-1:0] ry_next;
  logic [ADDR_W-1:0] dir_addr;
  logic [DATA_W-1:0] load_val;
  logic [DATA_W-1:0] store_val;

  pm_lsu_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_int)
  );

  pm_lsu_decode u_decode (
    .instr_i (uinstr_i),
    .uop_o   (dec_uop)
  );

  pm_lsu_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start_i     (ustart_i),
    .dec_valid_i (dec_uop.valid),
    .is_load_i   (uop_q.is_load),
    .upd_en_i    (uop_q.upd_en),
    .mem_rdy_i   (mem_rdy_i),
    .state_o     (state),
    .accept_o    (accept),
    .capture_o   (capture)
  );

  pm_lsu_addrmod #(
    .AW    (ADDR_W),
    .MOD_W (MOD_W)
  ) u_addrmod (
    .base_i (ry_q),
    .mod_i  (uop_q.mod),
    .next_o (ry_next)
  );

  // operand and result registers: data only, loaded under explicit enables
  always_ff @(posedge clk) begin
    if (accept) begin
      uop_q <= dec_uop;
      rx_q  <= rf_rd_x_data_i;
      ry_q  <= ADDR_W'(rf_rd_y_data_i);
    end
  end

  always_ff @(posedge clk) begin
    if (capture) begin
      rdata_q <= mem_rdata_i;
    end
  end

  assign rf_rd_x_addr_o = dec_uop.rx;
  assign rf_rd_y_addr_o = dec_uop.ry;

  assign dir_addr  = {{DPAD_W{1'b0}}, uop_q.dir, 1'b0};
  assign store_val = uop_q.is_half ? rx_q : {{HI_W{1'b0}}, rx_q[BYTE_W-1:0]};
  assign load_val  = uop_q.is_half ? rdata_q
                                   : {rx_q[DATA_W-1:BYTE_W], rdata_q[BYTE_W-1:0]};

  always_comb begin
    mem_req_o   = (state == ST_ACCESS) & uop_q.valid;
    mem_addr_o  = uop_q.indirect ? ry_q : dir_addr;
    mem_half_o  = mem_req_o & uop_q.is_half;
    mem_we_o    = mem_req_o & ~uop_q.is_load;
    mem_wdata_o = mem_we_o ? store_val : '0;
  end

  always_comb begin
    rf_wr_en_o   = (state == ST_WDATA) | (state == ST_WADDR);
    rf_wr_addr_o = (state == ST_WADDR) ? uop_q.ry : uop_q.rx;
    rf_wr_data_o = (state == ST_WADDR) ? DATA_W'(ry_next) : load_val;
    done_o       = (state == ST_DONE);
  end

endmodule

// File: rtl/pm_lsu_chk.sv
module pm_lsu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done_o,
  input logic        rf_wr_en_o,
  input logic        mem_req_o,
  input logic [15:0] mem_addr_o,
  input logic        mem_half_o,
  input logic        mem_we_o,
  input logic [15:0] mem_wdata_o,
  input logic        mem_rdy_i
);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_we_o) && $stable(mem_half_o) && $stable(mem_wdata_o)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11
  done_after_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(mem_req_o || rf_wr_en_o));

  // R11
  req_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !rf_wr_en_o && !done_o);

  // R5
  byte_store_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && !mem_half_o) |-> (mem_wdata_o[15:8] == 8'h00));

  // R1
  we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_req_o);

endmodule

bind pm_lsu pm_lsu_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done_o      (done_o),
  .rf_wr_en_o  (rf_wr_en_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_half_o  (mem_half_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdy_i   (mem_rdy_i)
);

// File: tb/pm_lsu_bench.sv
module pm_lsu_bench;

  localparam int K_ACC  = 0;
  localparam int K_WR   = 1;
  localparam int K_DONE = 2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic        we;
    logic        half;
    logic [15:0] wd;
    logic [3:0]  wa;
  } step_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] uinstr;
  logic        ustart;
  logic        done;
  logic [3:0]  rxa, rya, wa;
  logic [15:0] rxd, ryd, wdat;
  logic        rf_we;
  logic        mem_req, mem_half, mem_we, mem_rdy;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  logic [15:0] rf  [16];
  logic [15:0] mrf [16];
  step_t       q[$];
  string       tq[$];
  string       cur_tag;
  bit          chk_on = 1'b0;
  int          total = 0;
  int          bad = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] seed = 16'h1D37;

  always #10 clk = ~clk;

  pm_lsu u_pm_lsu (
    .clk(clk), .rst_n(rst_n), .uinstr_i(uinstr), .ustart_i(ustart), .done_o(done),
    .rf_rd_x_addr_o(rxa), .rf_rd_x_data_i(rxd), .rf_rd_y_addr_o(rya), .rf_rd_y_data_i(ryd),
    .rf_wr_en_o(rf_we), .rf_wr_addr_o(wa), .rf_wr_data_o(wdat),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_half_o(mem_half), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_rdy_i(mem_rdy)
  );

  function automatic logic [15:0] rdf(input logic [15:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] ^ 8'hC5};
  endfunction

  assign rxd       = rf[rxa];
  assign ryd       = rf[rya];
  assign mem_rdata = rdf(mem_addr);

  always @(posedge clk) if (rf_we) rf[wa] <= wdat;

  always @(negedge clk) begin
    lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_rdy <= lfsr[0] | lfsr[4];
  end

  task automatic chk(input bit ok, input string t, input logic [63:0] a, input logic [63:0] e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", t, a, e, $time);
    end
  endtask

  function automatic bit supported(input logic [3:0] op);
    return op inside {4'h2, 4'h3, 4'h5, 4'h6, 4'h7, 4'hD};
  endfunction

  function automatic void push(input int k, input logic [15:0] a, input logic we,
                               input logic half, input logic [15:0] d, input logic [3:0] r,
                               input string t);
    step_t s;
    s.kind = 2'(k); s.addr = a; s.we = we; s.half = half; s.wd = d; s.wa = r;
    q.push_back(s);
    tq.push_back(t);
  endfunction

  function automatic void build(input logic [15:0] ins, input string t);
    logic [3:0]  op = ins[15:12];
    logic [3:0]  x  = ins[11:8];
    logic [3:0]  y  = ins[7:4];
    logic [3:0]  m  = ins[3:0];
    logic [15:0] a  = mrf[y];
    logic [15:0] da = {7'b0, ins[7:0], 1'b0};
    logic [15:0] na;
    int          dl;
    case (op)
      4'h6: begin push(K_ACC, a, 0, 0, 0, 0, t); push(K_WR, 0, 0, 0, {mrf[x][15:8], rdf(a)[7:0]}, x, t); end
      4'hD: begin push(K_ACC, a, 0, 1, 0, 0, t); push(K_WR, 0, 0, 0, rdf(a), x, t); end
      4'h7: push(K_ACC, a, 1, 0, {8'h00, mrf[x][7:0]}, 0, t);
      4'h5: push(K_ACC, a, 1, 1, mrf[x], 0, t);
      4'h2: begin push(K_ACC, da, 0, 1, 0, 0, t); push(K_WR, 0, 0, 0, rdf(da), x, t); end
      default: push(K_ACC, da, 1, 1, mrf[x], 0, t);
    endcase
    if (op != 4'h2 && op != 4'h3 && m < 8) begin
      dl = (m < 4) ? int'(m) + 1 : -(int'(m) - 3);
      na = a + 16'(dl);
      push(K_WR, 0, 0, 0, na, y, "R7");
    end
    push(K_DONE, 0, 0, 0, 0, 0, "R11");
  endfunction

  // reference model advance
  always @(posedge clk) begin
    bit was_empty;
    was_empty = (q.size() == 0);
    if (!rst_n) begin
      q.delete(); tq.delete();
    end else begin
      if (!was_empty) begin
        if (q[0].kind == 2'(K_ACC)) begin
          if (mem_rdy) begin void'(q.pop_front()); void'(tq.pop_front()); end
        end else begin
          if (q[0].kind == 2'(K_WR)) mrf[q[0].wa] = q[0].wd;
          void'(q.pop_front()); void'(tq.pop_front());
        end
      end
      if (was_empty && ustart && supported(uinstr[15:12])) build(uinstr, cur_tag);
    end
  end

  // per-cycle port comparison
  always @(negedge clk) begin
    logic [56:0] act, exp;
    string t;
    if (chk_on) begin
      act = '0; exp = '0;
      act[56] = mem_req;
      if (mem_req) begin act[55] = mem_we; act[54] = mem_half; act[53:38] = mem_addr; end
      if (mem_req && mem_we) act[37:22] = mem_wdata;
      act[21] = rf_we;
      if (rf_we) begin act[20:17] = wa; act[16:1] = wdat; end
      act[0] = done;
      t = cur_tag;
      if (q.size() != 0) begin
        t = tq[0];
        case (int'(q[0].kind))
          K_ACC: begin
            exp[56] = 1'b1; exp[55] = q[0].we; exp[54] = q[0].half; exp[53:38] = q[0].addr;
            if (q[0].we) exp[37:22] = q[0].wd;
          end
          K_WR: begin exp[21] = 1'b1; exp[20:17] = q[0].wa; exp[16:1] = q[0].wd; end
          default: exp[0] = 1'b1;
        endcase
      end
      chk(act == exp, t, 64'(act), 64'(exp));
    end
  end

  task automatic set_reg(input int i, input logic [15:0] v);
    rf[i] = v; mrf[i] = v;
  endtask

  task automatic issue(input logic [15:0] ins, input string t, input bit poke);
    uinstr = ins; ustart = 1'b1; cur_tag = t;
    @(negedge clk);
    if (poke) begin
      uinstr = 16'h6112;
      @(negedge clk);
    end
    ustart = 1'b0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] ops [6];
    ops = '{4'h2, 4'h3, 4'h5, 4'h6, 4'h7, 4'hD};
    rst_n = 1'b0; ustart = 1'b0; uinstr = 16'h0000; cur_tag = "R1";
    for (int i = 0; i < 16; i++) set_reg(i, 16'h1000 + 16'(i) * 16'h0111);
    repeat (2) @(negedge clk);
    chk_on = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mem_req && !rf_we && !done, "R1", {61'b0, mem_req, rf_we, done}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_req && !rf_we && !done, "R1", {61'b0, mem_req, rf_we, done}, 64'h0);

    // unsupported opcodes
    foreach (ops[k]) begin end
    for (int o = 0; o < 16; o++) begin
      if (!supported(4'(o))) issue({4'(o), 12'h4A1}, "R2", 1'b0);
    end
    chk(rf[4] == mrf[4] && rf[10] == mrf[10], "R2", {32'(rf[4]), 32'(rf[10])}, {32'(mrf[4]), 32'(mrf[10])});

    // byte load keeps the high byte
    set_reg(1, 16'hABCD); set_reg(4, 16'h0200);
    issue(16'h6140, "R3", 1'b0);
    chk(rf[1] == 16'hABC7, "R3", 64'(rf[1]), 64'hABC7);
    chk(rf[4] == 16'h0201, "R8", 64'(rf[4]), 64'h0201);

    // every modifier for each indirect form
    for (int m = 0; m < 16; m++) begin
      issue({4'h6, 4'h1, 4'h4, 4'(m)}, "R3", 1'b0);
      issue({4'hD, 4'h5, 4'h6, 4'(m)}, "R4", 1'b0);
      issue({4'h7, 4'h1, 4'h4, 4'(m)}, "R5", 1'b0);
      issue({4'h5, 4'h5, 4'h6, 4'(m)}, "R6", 1'b0);
    end
    chk(rf[6] == mrf[6], "R7", 64'(rf[6]), 64'(mrf[6]));

    // wrap-around in both directions
    set_reg(2, 16'h0000);
    issue(16'h7124, "R7", 1'b0);
    chk(rf[2] == 16'hFFFF, "R7", 64'(rf[2]), 64'hFFFF);
    set_reg(3, 16'hFFFF);
    issue(16'h5133, "R7", 1'b0);
    chk(rf[3] == 16'h0003, "R7", 64'(rf[3]), 64'h0003);

    // direct forms
    issue(16'h2A5A, "R9", 1'b0);
    chk(rf[10] == 16'h88C5, "R9", 64'(rf[10]), 64'h88C5);
    issue(16'h2BFF, "R9", 1'b0);
    chk(rf[11] == 16'hC2C4, "R9", 64'(rf[11]), 64'hC2C4);
    issue(16'h3A00, "R9", 1'b0);
    issue(16'h3B80, "R9", 1'b0);

    // same register as data and address
    set_reg(8, 16'h4000);
    issue(16'h6881, "R10", 1'b0);
    chk(rf[8] == 16'h4002, "R10", 64'(rf[8]), 64'h4002);
    set_reg(9, 16'h0001);
    issue(16'hD995, "R10", 1'b0);
    chk(rf[9] == 16'hFFFF, "R10", 64'(rf[9]), 64'hFFFF);

    // mixed traffic with starts while busy
    for (int n = 0; n < 60; n++) begin
      seed = {seed[14:0], seed[15] ^ seed[13] ^ seed[12] ^ seed[10]};
      issue({ops[int'(seed[2:0]) % 6], seed[11:0]}, "R11", (n % 3) == 0);
    end

    for (int i = 0; i < 16; i++) chk(rf[i] == mrf[i], "R7", 64'(rf[i]), 64'(mrf[i]));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule